// File: doc/BRIEF.md
# Protection Switching Byte Persistence Filter

This block watches the two protection switching bytes of the line overhead, sampled once per frame. It filters them through an N-frame persistence check, so a value only counts as received after it has arrived identically in N frames in a row. Two fields are filtered separately. The main field is 13 bits wide: all of the first byte, followed by the upper five bits of the second byte. The auxiliary field is the lower three bits of the second byte. Each field has its own candidate register, match counter, accepted value and change flag.

When the accepted value of a field changes, its sticky change flag is set. The flag stays set until the host clears it with a per-field clear strobe. The interrupt output is the OR of all flags whose mask bit is low. With every mask bit set, the host can run the block purely by polling. The block does not interpret switch requests.

Top module: `aps_persist_mon`

## Requirements
- R1: The main field is `{byteA[7:0], byteB[7:3]}`, with byteA in bits 12..5. It is accepted as one 13-bit unit on `mainAccepted`.
- R2: The auxiliary field is `byteB[2:0]`. It is filtered, accepted (`auxAccepted`) and change-flagged on its own, with no effect on the main field.
- R3: A candidate value replaces the accepted value at the clock edge that captures its N-th consecutive identical frame, and not earlier.
- R4: A frame whose field differs from the current candidate makes that value the new candidate, and the match count restarts at one.
- R5: `persistN` sets N from 1 to 15. A value of 0 acts as 1.
- R6: A change of an accepted value sets its sticky flag: bit 0 of `chgFlags` for the main field, bit 1 for the auxiliary field. A completed match that equals the stored value sets no flag.
- R7: A flag stays set until the host pulses the matching bit of `flagClear`.
- R8: `irq` is high exactly when some flag is set and its bit of `intMask` is 0. A mask bit of 1 removes that flag from the interrupt.
- R9: While reset is held, both accepted values read zero, both flags are clear and `irq` is low.
- R10: Cycles with `frameValid` low leave the accepted values and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | One-cycle strobe: the byte inputs hold this frame's values |
| byteA | input | 8 | First protection switching byte |
| byteB | input | 8 | Second protection switching byte |
| persistN | input | 4 | Number of consecutive identical frames required (0 acts as 1) |
| intMask | input | 2 | Interrupt mask per flag (1 = masked) |
| flagClear | input | 2 | Clear strobe per flag |
| mainAccepted | output | 13 | Accepted main field |
| auxAccepted | output | 3 | Accepted auxiliary field |
| chgFlags | output | 2 | Sticky change flags {aux, main} |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 4-bit count width. That brings both ends of the persistence range within reach: N of 0 acting as 1, and the full 15-frame wait. A table of frames with N set to 3 interleaves changes of the two fields, so that one field's restarts and acceptances can be seen not to disturb the other. Directed cases then cover mask combinations, per-flag clearing, re-acceptance of an unchanged value, ignored non-strobe cycles, and a candidate run broken by one odd frame.

// File: rtl/aps_mon_pkg.sv
package aps_mon_pkg;
  localparam int NUM_FIELDS = 2;
  localparam int FIELD_MAIN = 0;
  localparam int FIELD_AUX  = 1;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] restart;  // load a new candidate
    logic [NUM_FIELDS-1:0] accept;   // copy the input into the accepted register
  } apsStrobes_t;
endpackage

// File: rtl/aps_mon_ctrl.sv
module aps_mon_ctrl
  import aps_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameValid,
  input  logic [CNT_W-1:0]      persistN,
  input  logic [NUM_FIELDS-1:0] candMatch,
  input  logic [NUM_FIELDS-1:0] accMatch,
  output apsStrobes_t           strobes
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]      needCount;
  logic [NUM_FIELDS-1:0] restartVec;
  logic [NUM_FIELDS-1:0] acceptVec;

  assign needCount = (persistN == '0) ? CNT_ONE : persistN;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    logic [CNT_W-1:0] runCount;
    logic [CNT_W-1:0] nextCount;

    always_comb begin
      if (!candMatch[g])           nextCount = CNT_ONE;
      else if (runCount == CNT_MAX) nextCount = runCount;
      else                          nextCount = runCount + CNT_ONE;
    end

    assign restartVec[g] = frameValid && !candMatch[g];
    assign acceptVec[g]  = frameValid && (nextCount >= needCount) && !accMatch[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           runCount <= '0;
      else if (frameValid) runCount <= nextCount;
    end
  end

  assign strobes = '{restart: restartVec, accept: acceptVec};
endmodule

// File: rtl/aps_mon_dp.sv
module aps_mon_dp
  import aps_mon_pkg::*;
#(
  parameter int MAIN_W = 13,
  parameter int AUX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [MAIN_W-1:0]     mainIn,
  input  logic [AUX_W-1:0]      auxIn,
  input  apsStrobes_t           strobes,
  input  logic [NUM_FIELDS-1:0] flagClear,
  output logic [MAIN_W-1:0]     mainAcc,
  output logic [AUX_W-1:0]      auxAcc,
  output logic [NUM_FIELDS-1:0] chgFlags,
  output logic [NUM_FIELDS-1:0] candMatch,
  output logic [NUM_FIELDS-1:0] accMatch
);
  logic [MAIN_W-1:0] mainCand;
  logic [AUX_W-1:0]  auxCand;

  assign candMatch[FIELD_MAIN] = (mainIn == mainCand);
  assign candMatch[FIELD_AUX]  = (auxIn == auxCand);
  assign accMatch[FIELD_MAIN]  = (mainIn == mainAcc);
  assign accMatch[FIELD_AUX]   = (auxIn == auxAcc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCand <= '0;
      auxCand  <= '0;
      mainAcc  <= '0;
      auxAcc   <= '0;
    end else begin
      if (strobes.restart[FIELD_MAIN]) mainCand <= mainIn;
      if (strobes.restart[FIELD_AUX])  auxCand  <= auxIn;
      if (strobes.accept[FIELD_MAIN])  mainAcc  <= mainIn;
      if (strobes.accept[FIELD_AUX])   auxAcc   <= auxIn;
    end
  end

  // A new change takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chgFlags <= '0;
    else       chgFlags <= strobes.accept | (chgFlags & ~flagClear);
  end
endmodule

// File: rtl/aps_persist_mon.sv
module aps_persist_mon
  import aps_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic [7:0]       byteA,
  input  logic [7:0]       byteB,
  input  logic [CNT_W-1:0] persistN,
  input  logic [1:0]       intMask,
  input  logic [1:0]       flagClear,
  output logic [12:0]      mainAccepted,
  output logic [2:0]       auxAccepted,
  output logic [1:0]       chgFlags,
  output logic             irq
);
  localparam int AUX_W  = 3;
  localparam int MAIN_W = 8 + (8 - AUX_W);

  apsStrobes_t           strobes;
  logic [NUM_FIELDS-1:0] candMatch;
  logic [NUM_FIELDS-1:0] accMatch;

  aps_mon_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .persistN(persistN),
    .candMatch(candMatch), .accMatch(accMatch), .strobes(strobes)
  );

  aps_mon_dp #(.MAIN_W(MAIN_W), .AUX_W(AUX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .mainIn({byteA, byteB[7:AUX_W]}), .auxIn(byteB[AUX_W-1:0]),
    .strobes(strobes), .flagClear(flagClear),
    .mainAcc(mainAccepted), .auxAcc(auxAccepted), .chgFlags(chgFlags),
    .candMatch(candMatch), .accMatch(accMatch)
  );

  assign irq = |(chgFlags & ~intMask);
endmodule

// File: rtl/aps_persist_mon_chk.sv
module aps_persist_mon_chk (
  input logic        clk,
  input logic        rstN,
  input logic        frameValid,
  input logic [7:0]  byteA,
  input logic [7:0]  byteB,
  input logic [1:0]  intMask,
  input logic [1:0]  flagClear,
  input logic [12:0] mainAccepted,
  input logic [2:0]  auxAccepted,
  input logic [1:0]  chgFlags,
  input logic        irq
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> ($stable(mainAccepted) && $stable(auxAccepted))); // R10

  AST_MAIN_FROM_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mainAccepted) |-> (mainAccepted == $past({byteA, byteB[7:3]}))); // R1

  AST_AUX_FROM_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(auxAccepted) |-> (auxAccepted == $past(byteB[2:0]))); // R2

  AST_MAIN_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mainAccepted) |-> chgFlags[0]); // R6

  AST_AUX_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(auxAccepted) |-> chgFlags[1]); // R6

  AST_MAIN_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlags[0] && !flagClear[0]) |=> chgFlags[0]); // R7

  AST_AUX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlags[1] && !flagClear[1]) |=> chgFlags[1]); // R7

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (intMask == 2'b11) |-> !irq); // R8

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_ZERO: assert (mainAccepted == '0 && auxAccepted == '0 && chgFlags == '0 && !irq); // R9
    end
  end
endmodule

bind aps_persist_mon aps_persist_mon_chk u_chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .byteA(byteA), .byteB(byteB),
  .intMask(intMask), .flagClear(flagClear), .mainAccepted(mainAccepted),
  .auxAccepted(auxAccepted), .chgFlags(chgFlags), .irq(irq)
);

// File: tb/aps_persist_mon_tb.sv
module aps_persist_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {byteA, byteB, expected main, expected aux}, N = 3
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h12, 8'h35, 13'h0000, 3'd0},
    {8'h12, 8'h35, 13'h0000, 3'd0},
    {8'h12, 8'h35, 13'h0246, 3'd5},
    {8'h12, 8'h36, 13'h0246, 3'd5},
    {8'h99, 8'h36, 13'h0246, 3'd5},
    {8'h12, 8'h36, 13'h0246, 3'd6},
    {8'h99, 8'h36, 13'h0246, 3'd6},
    {8'h99, 8'h36, 13'h0246, 3'd6},
    {8'h99, 8'h36, 13'h1326, 3'd6}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [7:0]  byteA = '0;
  logic [7:0]  byteB = '0;
  logic [3:0]  persistN = 4'd3;
  logic [1:0]  intMask = '0;
  logic [1:0]  flagClear = '0;
  logic [12:0] mainAccepted;
  logic [2:0]  auxAccepted;
  logic [1:0]  chgFlags;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aps_persist_mon u_dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .byteA(byteA), .byteB(byteB),
    .persistN(persistN), .intMask(intMask), .flagClear(flagClear),
    .mainAccepted(mainAccepted), .auxAccepted(auxAccepted), .chgFlags(chgFlags), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    byteA = a; byteB = b; frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic pulseClear(input logic [1:0] m);
    @(negedge clk);
    flagClear = m;
    @(negedge clk);
    flagClear = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 main", 32'(mainAccepted), 0);
    check("R9 aux", 32'(auxAccepted), 0);
    check("R9 flags", 32'(chgFlags), 0);
    check("R9 irq", 32'(irq), 0);
    rstN = 1'b1;

    // Table: R1 R2 R3 R4 with N = 3
    for (int i = 0; i < NVEC; i++) begin
      sendFrame(VEC[i][31:24], VEC[i][23:16]);
      check("R1/R3 main", 32'(mainAccepted), 32'(VEC[i][15:3]));
      check("R2/R4 aux", 32'(auxAccepted), 32'(VEC[i][2:0]));
    end

    // R8 masking
    check("R6 flags after table", 32'(chgFlags), 32'd3);
    check("R8 irq unmasked", 32'(irq), 1);
    intMask = 2'b01; #1;
    check("R8 irq aux only", 32'(irq), 1);
    intMask = 2'b11; #1;
    check("R8 irq fully masked", 32'(irq), 0);
    check("R8 flags kept under mask", 32'(chgFlags), 32'd3);
    intMask = 2'b10; #1;
    check("R8 irq main only", 32'(irq), 1);
    intMask = 2'b00;

    // R7 clearing
    pulseClear(2'b01);
    check("R7 clear main only", 32'(chgFlags), 32'd2);
    repeat (10) @(negedge clk);
    check("R7 flag held while idle", 32'(chgFlags), 32'd2);
    pulseClear(2'b10);
    check("R7 clear aux", 32'(chgFlags), 32'd0);
    check("R8 irq after clear", 32'(irq), 0);

    // R6 unchanged value re-accepted: no flag
    repeat (3) sendFrame(8'h99, 8'h36);
    check("R6 same value main", 32'(mainAccepted), 32'h1326);
    check("R6 no flag on same value", 32'(chgFlags), 32'd0);

    // R10 ignored without strobe
    @(negedge clk);
    byteA = 8'h55; byteB = 8'hAA;
    repeat (20) @(negedge clk);
    check("R10 main held", 32'(mainAccepted), 32'h1326);
    check("R10 aux held", 32'(auxAccepted), 32'd6);
    check("R10 flags held", 32'(chgFlags), 32'd0);

    // R5 N of 0 acts as 1
    persistN = 4'd0;
    sendFrame(8'h01, 8'h00);
    check("R5 N=0 main", 32'(mainAccepted), 32'h0020);
    check("R5 N=0 aux", 32'(auxAccepted), 32'd0);
    check("R6 both flags", 32'(chgFlags), 32'd3);
    pulseClear(2'b11);

    // R5 / R3 N = 15
    persistN = 4'd15;
    repeat (14) sendFrame(8'h02, 8'h00);
    check("R3 N=15 after 14 frames", 32'(mainAccepted), 32'h0020);
    sendFrame(8'h02, 8'h00);
    check("R5 N=15 after 15 frames", 32'(mainAccepted), 32'h0040);

    // R4 broken run
    persistN = 4'd2;
    sendFrame(8'h03, 8'h00);
    sendFrame(8'h04, 8'h00);
    check("R4 odd frame", 32'(mainAccepted), 32'h0040);
    sendFrame(8'h03, 8'h00);
    check("R4 restarted count", 32'(mainAccepted), 32'h0040);
    sendFrame(8'h03, 8'h00);
    check("R4 accepted after restart", 32'(mainAccepted), 32'h0060);

    // R2 aux independent of main
    pulseClear(2'b11);
    sendFrame(8'h03, 8'h07);
    sendFrame(8'h03, 8'h07);
    check("R2 aux accepted", 32'(auxAccepted), 32'd7);
    check("R2 main untouched", 32'(mainAccepted), 32'h0060);
    check("R2 only aux flag", 32'(chgFlags), 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule